// File: doc/BRIEF.md
# Time-Multiplexed Servo Pulse Generator

This block drives a bank of hobby-servo control lines from one shared time base. Every output goes high at the same instant at the start of each frame. After a fixed lead-in, each line drops at a moment set by an 8-bit position code for that channel. With the default settings the system clock is 48 MHz, the tick is 200 clocks (about 4.17 us, half a degree of travel), the frame is 4800 ticks (20 ms) and the lead-in is 232 ticks. This gives pulses from roughly 0.97 ms to 2.03 ms, and the mid code gives 1.5 ms.

The position codes are held in two small RAMs and not in per-channel registers. A staging RAM takes host writes at any time. At each frame start its whole content is copied into a live RAM, so a frame never sees a mix of old and new settings. Each tick inside the 256-tick compare window starts a sweep. The sweep reads the live RAM one channel per clock and drops an output when its code equals the window position. One comparator therefore serves every channel.

Settings arrive on a write-only SPI mode-0 port. The word is 16 bits, most significant bit first, and is committed when chip select goes high. The host sends a signed angle, and the block stores it as an offset-binary code.

Top module: `srvp_multi_servo`

## Requirements
- R1: A frame lasts exactly FRAME_TICKS x CLK_DIV clocks, so the rising edges of any output are spaced by that many clocks.
- R2: At each frame start all NUM_CH outputs rise on the same clock.
- R3: The high time of channel n with stored code c is exactly CLK_DIV x (LEAD_TICKS + 1 + c) + n + 2 clocks. The n + 2 term comes from the one-channel-per-clock sweep and the RAM read latency.
- R4: A serial word is 16 bits, sampled on rising serial-clock edges while chip select is low, most significant bit first. Bits 15:8 are the address byte, and only its low log2(NUM_CH) bits (bits 13:8 for 64 channels) select the channel. Its upper bits are ignored. Bits 7:0 are the data byte.
- R5: A word is committed on the rising edge of chip select. The stored code is the data byte with bit 7 inverted, so a signed value v in -128..127 becomes code v + 128 and zero becomes 128.
- R6: A setting written during a frame has no effect on that frame's pulses. It applies from the next frame start.
- R7: After reset every output stays low until the first frame start, and every channel holds code 128.
- R8: A transfer with any number of clock edges commits the last 16 bits shifted in, including bits left over from earlier transfers.
- R9: Serial-clock edges while chip select is high shift nothing.
- R10: A channel that is not written keeps its code across frames.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock, idle low, asynchronous to clk |
| spi_mosi | input | 1 | Serial data in |
| spi_cs_n | input | 1 | Active-low chip select; its rising edge commits the word |
| servo_pwm | output | NUM_CH | One servo pulse train per channel |

## Verification
A wrong sweep index or a mishandled read latency shows up as pulse widths off by a few clocks on every channel in the very first frame. This is why widths are measured to the exact clock for codes 0, 128 and 255 on channels 0, 1, 62 and 63. A copy that is missing or mistimed shows up in the frame that follows a write. It appears either as a change in the frame being written, or as a channel that was not written and drifts to a stale value one frame later. Faults in the serial path change which channel moves and by how much. Every batch of writes is therefore checked against all 64 widths of the next frame.

// File: rtl/srvp_pkg.sv
package srvp_pkg;
  // Width of a position code and of the compare window it indexes.
  localparam int SRVP_CODE_W  = 8;
  localparam int SRVP_WINDOW  = 1 << SRVP_CODE_W;
  localparam logic [SRVP_CODE_W-1:0] SRVP_NEUTRAL = 8'd128;

  // Signed host angle to offset-binary position code.
  function automatic logic [SRVP_CODE_W-1:0] srvp_offset_code(input logic [SRVP_CODE_W-1:0] sval);
    return {~sval[SRVP_CODE_W-1], sval[SRVP_CODE_W-2:0]};
  endfunction
endpackage

// File: rtl/srvp_dpram.sv
module srvp_dpram #(
  parameter int DEPTH = 64,
  parameter int WIDTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // One write port, one registered read port (read-before-write).
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/srvp_timebase.sv
module srvp_timebase
  import srvp_pkg::*;
#(
  parameter int CLK_DIV     = 200,
  parameter int FRAME_TICKS = 4800,
  parameter int LEAD_TICKS  = 232
) (
  input  logic                   clk,
  input  logic                   rst_n,
  output logic                   frame_start,
  output logic                   win_tick,
  output logic [SRVP_CODE_W-1:0] win_idx
);
  localparam int PW = $clog2(CLK_DIV);
  localparam int TW = $clog2(FRAME_TICKS);
  localparam logic [PW-1:0] PRE_LOAD = PW'(CLK_DIV - 1);
  localparam logic [TW-1:0] T_LAST   = TW'(FRAME_TICKS - 1);
  localparam logic [TW-1:0] T_LEAD   = TW'(LEAD_TICKS);
  localparam logic [TW-1:0] T_WIN    = TW'(SRVP_WINDOW);

  logic [PW-1:0] pre;
  logic [TW-1:0] tcnt;
  logic [TW-1:0] rel;
  logic          tick;

  assign tick        = (pre == '0);
  assign frame_start = tick && (tcnt == T_LAST);
  assign rel         = tcnt - T_LEAD;
  assign win_tick    = tick && (tcnt >= T_LEAD) && (rel < T_WIN);
  assign win_idx     = rel[SRVP_CODE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre  <= PRE_LOAD;
      tcnt <= '0;
    end else begin
      pre <= tick ? PRE_LOAD : pre - 1'b1;
      if (tick) tcnt <= (tcnt == T_LAST) ? '0 : tcnt + 1'b1;
    end
  end

  AST_TICK_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
  AST_FRAME_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (tcnt == '0)); // R1
endmodule

// File: rtl/srvp_spi_rx.sv
module srvp_spi_rx
  import srvp_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int AW     = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   sclk,
  input  logic                   mosi,
  input  logic                   cs_n,
  output logic                   wr_en,
  output logic [AW-1:0]          wr_addr,
  output logic [SRVP_CODE_W-1:0] wr_code
);
  localparam int WW = 2 * SRVP_CODE_W;

  logic sclk_m, sclk_s, sclk_d;
  logic cs_m, cs_s, cs_d;
  logic mosi_m, mosi_s;
  logic [WW-1:0] sh;
  logic sclk_rise, cs_rise, shift_fire;

  assign sclk_rise  = sclk_s & ~sclk_d;
  assign cs_rise    = cs_s & ~cs_d;
  assign shift_fire = sclk_rise & ~cs_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {sclk_m, sclk_s, sclk_d} <= '0;
      {cs_m, cs_s, cs_d}       <= '1;
      {mosi_m, mosi_s}         <= '0;
      sh                       <= '0;
    end else begin
      sclk_m <= sclk;  sclk_s <= sclk_m;  sclk_d <= sclk_s;
      cs_m   <= cs_n;  cs_s   <= cs_m;    cs_d   <= cs_s;
      mosi_m <= mosi;  mosi_s <= mosi_m;
      if (shift_fire) sh <= {sh[WW-2:0], mosi_s};
    end
  end

  assign wr_en   = cs_rise;
  assign wr_addr = sh[SRVP_CODE_W +: AW];
  assign wr_code = srvp_offset_code(sh[SRVP_CODE_W-1:0]);

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    cs_s |=> $stable(sh)); // R9
  AST_COMMIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en); // R5
endmodule

// File: rtl/srvp_bank_ctrl.sv
module srvp_bank_ctrl
  import srvp_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int AW     = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic                   ser_we,
  input  logic [AW-1:0]          ser_addr,
  input  logic [SRVP_CODE_W-1:0] ser_code,
  input  logic [SRVP_CODE_W-1:0] stg_rdata,
  output logic                   stg_we,
  output logic [AW-1:0]          stg_waddr,
  output logic [SRVP_CODE_W-1:0] stg_wdata,
  output logic [AW-1:0]          stg_raddr,
  output logic                   live_we,
  output logic [AW-1:0]          live_waddr,
  output logic [SRVP_CODE_W-1:0] live_wdata,
  output logic                   copy_active
);
  localparam logic [AW-1:0] LAST_CH = AW'(NUM_CH - 1);

  logic          ini_busy;
  logic [AW-1:0] ini_idx;
  logic          cp_busy, cp_v;
  logic [AW-1:0] cp_idx, cp_idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ini_busy <= 1'b1;
      ini_idx  <= '0;
      cp_busy  <= 1'b0;
      cp_idx   <= '0;
      cp_v     <= 1'b0;
      cp_idx_q <= '0;
    end else begin
      if (ini_busy) begin
        ini_idx <= ini_idx + 1'b1;
        if (ini_idx == LAST_CH) ini_busy <= 1'b0;
      end
      if (frame_start) begin
        cp_busy <= 1'b1;
        cp_idx  <= '0;
      end else if (cp_busy) begin
        cp_idx <= cp_idx + 1'b1;
        if (cp_idx == LAST_CH) cp_busy <= 1'b0;
      end
      cp_v     <= cp_busy;
      cp_idx_q <= cp_idx;
    end
  end

  // Staging bank: reset fill first, host writes otherwise.
  assign stg_we    = ini_busy | ser_we;
  assign stg_waddr = ini_busy ? ini_idx : ser_addr;
  assign stg_wdata = ini_busy ? SRVP_NEUTRAL : ser_code;
  assign stg_raddr = cp_idx;

  // Live bank: reset fill, then frame-start copy from staging.
  assign live_we    = ini_busy | cp_v;
  assign live_waddr = ini_busy ? ini_idx : cp_idx_q;
  assign live_wdata = ini_busy ? SRVP_NEUTRAL : stg_rdata;

  assign copy_active = cp_busy | cp_v;

  AST_COPY_ON_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cp_busy) |-> $past(frame_start)); // R6
  AST_INIT_BEFORE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    ini_busy |-> !cp_busy); // R7
endmodule

// File: rtl/srvp_sweep.sv
module srvp_sweep
  import srvp_pkg::*;
#(
  parameter int NUM_CH = 64,
  parameter int AW     = $clog2(NUM_CH)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   frame_start,
  input  logic                   win_tick,
  input  logic [SRVP_CODE_W-1:0] win_idx,
  input  logic [SRVP_CODE_W-1:0] live_rdata,
  output logic [AW-1:0]          live_raddr,
  output logic [NUM_CH-1:0]      servo_pwm
);
  localparam logic [AW-1:0] LAST_CH = AW'(NUM_CH - 1);

  logic                   busy;
  logic [AW-1:0]          ridx;
  logic [SRVP_CODE_W-1:0] wval;
  logic                   rd_v;
  logic [AW-1:0]          rd_ch;
  logic                   hit;

  assign live_raddr = ridx;
  assign hit        = rd_v && (live_rdata == wval);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ridx  <= '0;
      wval  <= '0;
      rd_v  <= 1'b0;
      rd_ch <= '0;
    end else begin
      if (win_tick) begin
        busy <= 1'b1;
        ridx <= '0;
        wval <= win_idx;
      end else if (busy) begin
        ridx <= ridx + 1'b1;
        if (ridx == LAST_CH) busy <= 1'b0;
      end
      rd_v  <= busy;
      rd_ch <= ridx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           servo_pwm        <= '0;
    else if (frame_start) servo_pwm        <= '1;
    else if (hit)         servo_pwm[rd_ch] <= 1'b0;
  end

  AST_RISE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (&servo_pwm)); // R2
  AST_NO_STRAY_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_start) |-> ((servo_pwm & ~$past(servo_pwm)) == '0)); // R7
  AST_ONE_FALL_PER_CLK: assert property (@(posedge clk) disable iff (!rst_n)
    $countones($past(servo_pwm) & ~servo_pwm) <= 1); // R3
  AST_SWEEP_FITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    win_tick |-> !busy); // R3
endmodule

// File: rtl/srvp_multi_servo.sv
module srvp_multi_servo
  import srvp_pkg::*;
#(
  parameter int NUM_CH      = 64,
  parameter int CLK_DIV     = 200,
  parameter int FRAME_TICKS = 4800,
  parameter int LEAD_TICKS  = 232
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  output logic [NUM_CH-1:0] servo_pwm
);
  localparam int AW = $clog2(NUM_CH);

  logic                   frame_start, win_tick;
  logic [SRVP_CODE_W-1:0] win_idx;
  logic                   ser_we;
  logic [AW-1:0]          ser_addr;
  logic [SRVP_CODE_W-1:0] ser_code;
  logic                   stg_we, live_we, copy_active;
  logic [AW-1:0]          stg_waddr, stg_raddr, live_waddr, live_raddr;
  logic [SRVP_CODE_W-1:0] stg_wdata, stg_rdata, live_wdata, live_rdata;

  srvp_timebase #(.CLK_DIV(CLK_DIV), .FRAME_TICKS(FRAME_TICKS), .LEAD_TICKS(LEAD_TICKS)) u_tb (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .win_tick(win_tick), .win_idx(win_idx));

  srvp_spi_rx #(.NUM_CH(NUM_CH)) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .wr_en(ser_we), .wr_addr(ser_addr), .wr_code(ser_code));

  srvp_bank_ctrl #(.NUM_CH(NUM_CH)) u_bank (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
    .ser_we(ser_we), .ser_addr(ser_addr), .ser_code(ser_code),
    .stg_rdata(stg_rdata), .stg_we(stg_we), .stg_waddr(stg_waddr),
    .stg_wdata(stg_wdata), .stg_raddr(stg_raddr), .live_we(live_we),
    .live_waddr(live_waddr), .live_wdata(live_wdata), .copy_active(copy_active));

  srvp_dpram #(.DEPTH(NUM_CH), .WIDTH(SRVP_CODE_W)) u_stage_ram (
    .clk(clk), .we(stg_we), .waddr(stg_waddr), .wdata(stg_wdata),
    .raddr(stg_raddr), .rdata(stg_rdata));

  srvp_dpram #(.DEPTH(NUM_CH), .WIDTH(SRVP_CODE_W)) u_live_ram (
    .clk(clk), .we(live_we), .waddr(live_waddr), .wdata(live_wdata),
    .raddr(live_raddr), .rdata(live_rdata));

  srvp_sweep #(.NUM_CH(NUM_CH)) u_sweep (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .win_tick(win_tick),
    .win_idx(win_idx), .live_rdata(live_rdata), .live_raddr(live_raddr),
    .servo_pwm(servo_pwm));

  AST_WINDOW_AFTER_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    win_tick |-> !copy_active); // R6
endmodule

// File: tb/test_srvp_multi_servo.sv
module test_srvp_multi_servo;
  localparam int NCH  = 64;
  localparam int DIV  = 70;
  localparam int LEAD = 4;
  localparam int FT   = LEAD + 256 + 2;
  localparam int WDOG = 150000;

  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic [NCH-1:0] pwm;

  always #10 clk = ~clk;

  srvp_multi_servo #(.NUM_CH(NCH), .CLK_DIV(DIV), .FRAME_TICKS(FT), .LEAD_TICKS(LEAD))
    i_srvp_multi_servo (.clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_mosi(mosi),
                        .spi_cs_n(cs_n), .servo_pwm(pwm));

  int cyc = 0;
  int n_run = 0, n_fail = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Port monitor: rise time and last high time per channel.
  logic [NCH-1:0] prev_pwm = '0;
  int rise_c [NCH];
  int width_c [NCH];
  int frame_cnt = 0, start_cur = 0, start_prev = 0;
  always @(negedge clk) begin
    for (int c = 0; c < NCH; c++) begin
      if (pwm[c] && !prev_pwm[c]) rise_c[c] = cyc;
      if (!pwm[c] && prev_pwm[c]) width_c[c] = cyc - rise_c[c];
    end
    if (pwm[0] && !prev_pwm[0]) begin
      start_prev = start_cur;
      start_cur  = cyc;
      frame_cnt  = frame_cnt + 1;
    end
    prev_pwm = pwm;
  end

  logic [7:0]  shadow_m [NCH];
  logic [7:0]  expect_m [NCH];
  logic [15:0] sh_m = '0;

  // High time: lead-in plus code ticks, one tick of alignment, then the sweep slot.
  function automatic int exp_width(input int ch, input int code);
    return (code + LEAD + 1) * DIV + 2 + ch;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spi_xfer(input logic [31:0] bits, input int nb);
    cs_n = 1'b0; clocks(4);
    for (int i = nb - 1; i >= 0; i--) begin
      mosi = bits[i]; clocks(4);
      sclk = 1'b1; sh_m = {sh_m[14:0], bits[i]}; clocks(4);
      sclk = 1'b0;
    end
    clocks(4); cs_n = 1'b1;
    shadow_m[sh_m[13:8]] = sh_m[7:0] ^ 8'h80;
    clocks(8);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    spi_xfer({16'h0, a, d}, 16);
  endtask

  task automatic check_frame(input string tag);
    for (int c = 0; c < NCH; c++) begin
      chk(width_c[c] == exp_width(c, int'(expect_m[c])), tag, width_c[c],
          exp_width(c, int'(expect_m[c])));
      width_c[c] = -1;
    end
  endtask

  task automatic at_frame(input int k);
    wait (frame_cnt == k);
    chk(pwm == '1, "R2", int'($countones(pwm)), NCH);
    if (k > 1) chk(start_cur - start_prev == FT * DIV, "R1", start_cur - start_prev, FT * DIV);
  endtask

  task automatic random_batch(input int n);
    for (int i = 0; i < n; i++) spi_xfer({16'h0, 16'($urandom)}, 16);
  endtask

  always @(posedge clk) begin
    if (cyc == WDOG) begin
      n_run++; n_fail++;
      $display("FAIL R1 watchdog expired actual=%0d expected=%0d", frame_cnt, 5);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20210729));
    for (int c = 0; c < NCH; c++) begin
      shadow_m[c] = 8'd128; width_c[c] = -1; rise_c[c] = 0;
    end
    clocks(5);
    chk(pwm == '0, "R7", int'($countones(pwm)), 0);
    rst_n = 1'b1;
    clocks(300);
    chk(pwm == '0, "R7", int'($countones(pwm)), 0);

    // Frame 1: neutral everywhere; writes here must wait for frame 2 (R6).
    at_frame(1);
    expect_m = shadow_m;
    wr(8'h00, 8'h80);   // ch0 code 0
    wr(8'hC1, 8'h80);   // ch1 code 0, upper address bits set (R4)
    wr(8'h3E, 8'h7F);   // ch62 code 255
    wr(8'h3F, 8'h7F);   // ch63 code 255
    wr(8'hDF, 8'h10);   // ch31 code 144 (R4)
    wr(8'h4A, 8'hF6);   // ch10 code 118 (R5)
    wr(8'h20, 8'h00);   // ch32 code 128 (R5)

    // Frame 2: long, short and idle-clock transfers (R8, R9).
    at_frame(2);
    check_frame("R6/R7");
    expect_m = shadow_m;
    spi_xfer(32'h00AA0555, 24);
    spi_xfer(32'h000002A3, 12);
    cs_n = 1'b1;
    for (int i = 0; i < 8; i++) begin
      mosi = 1'b1; clocks(4); sclk = 1'b1; clocks(4); sclk = 1'b0;
    end
    mosi = 1'b0;
    spi_xfer(32'h0, 0);

    // Frames 3 and 4: random writes; untouched channels must hold (R10).
    at_frame(3);
    check_frame("R3/R4/R5");
    expect_m = shadow_m;
    random_batch(20);

    at_frame(4);
    check_frame("R8/R9");
    expect_m = shadow_m;
    random_batch(20);

    at_frame(5);
    check_frame("R10");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule